// File: doc/BRIEF.md
# Dual-Issue Pairing Decision Unit

This block sits at the head of an issue window and looks at the two oldest pre-decoded instructions. Each one comes as a flat descriptor that carries class flags, operand-form bits, a byte length, a cache "seen before" marker and register read/write masks. From these the block decides whether the older instruction goes to the primary (U) pipe alone, or whether the younger one also goes to the secondary (V) pipe in the same cycle. With the decision it returns a 3-bit reason code that names the first rule that refused the pair.

The window side is a valid/ready stream. The window asserts `win_valid` while at least one descriptor is present, and `win_two` when a second one is present too. When `win_valid && win_ready` is true the block takes the descriptors. `win_pop2` then tells the window to drop two entries instead of one. The result goes into an output register that is read through `iss_valid`/`iss_ready`. While the output is held, `win_ready` is low and the window must keep its entries. A new result can be taken in the same cycle the old one is consumed.

Top module: `pair_issue_unit`

## Requirements
- R1: Descriptor layout at default parameters:
  - class bits [8:0], with simple=0, shift/rotate=1, carry-using ALU=2, jump/call/conditional jump=3, prefixed=4, push=5, pop=6, flag-writing ALU=7, conditional jump=8.
  - displacement bit 9, immediate bit 10, seen-before bit 11.
  - length [15:12].
  - read mask [24:16] and write mask [33:25]. In both masks bit 8 is the flags register and bit 4 is the stack pointer.
  - If either instruction lacks the simple bit, no pair is formed (reason 1).
- R2: A younger instruction that has the shift/rotate bit or the carry-using bit is refused (reason 2). The same applies to a younger instruction with the prefixed bit, unless it is also a conditional jump. These instructions pair normally in the older slot.
- R3: An older instruction with the jump/call bit is refused (reason 2). A younger conditional jump that also has the prefixed bit (the two-byte-escape form) may pair.
- R4: If either instruction has both the displacement bit and the immediate bit, the pair is refused (reason 3).
- R5: An older instruction with a length above 1 and a clear seen-before bit refuses the pair (reason 4).
- R6: A bit set in the older write mask and the younger read mask refuses the pair (reason 5). The flags bit is not counted when the older instruction is a flag-writing ALU op and the younger is a conditional jump.
- R7: A bit set in both write masks refuses the pair (reason 6). When both instructions are pushes, or both are pops, the stack-pointer bit is not counted for either the read-after-write check or the write-after-write check.
- R8: With `win_two` low, the older descriptor issues alone with reason 7 and no rule is applied.
- R9: The reason code is the lowest-numbered failing rule in the order 1..6. Code 0 means the pair issues, and only code 0 does so.
- R10: `win_ready` equals `!iss_valid || iss_ready`. A taken request appears on the outputs on the next clock edge. `win_pop2` is high exactly when a pair is taken. `iss_v_desc` is zero whenever `iss_dual` is low.
- R11: While `iss_valid && !iss_ready`, all outputs hold stable.
- R12: After reset `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| win_valid | input | 1 | Oldest window descriptor present |
| win_two | input | 1 | Second descriptor present |
| win_old | input | 34 | Older descriptor |
| win_yng | input | 34 | Younger descriptor |
| win_ready | output | 1 | Block can take the window head |
| win_pop2 | output | 1 | Two descriptors consumed this cycle |
| iss_valid | output | 1 | Issue result valid |
| iss_ready | input | 1 | Issue result consumed |
| iss_dual | output | 1 | Both slots issue |
| iss_reason | output | 3 | Pairing reason code |
| iss_u_desc | output | 34 | Descriptor sent to the U slot |
| iss_v_desc | output | 34 | Descriptor sent to the V slot, or zero |

## Verification
The bench uses the default build: eight general registers, the stack pointer at index 4 and a 4-bit length field. The masks are then only nine bits wide, so every ordered pair from a dozen instruction kinds can be crossed with three register-overlap patterns, and separately with all sixteen combinations of displacement/immediate, length and seen-before bits. This covers each slot restriction, both hazard exceptions and every priority collision between rules. Directed sequences add lone issue and a multi-cycle output stall.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int NFLAG = 9;
  localparam int F_SIMPLE  = 0;
  localparam int F_SHIFT   = 1;
  localparam int F_CARRY   = 2;
  localparam int F_BRANCH  = 3;
  localparam int F_PREFIX  = 4;
  localparam int F_PUSH    = 5;
  localparam int F_POP     = 6;
  localparam int F_FLAGALU = 7;
  localparam int F_JCC     = 8;

  localparam int NRULE = 6;

  typedef enum logic [2:0] {
    RSN_PAIR       = 3'd0,
    RSN_NOT_SIMPLE = 3'd1,
    RSN_SLOT       = 3'd2,
    RSN_DISP_IMM   = 3'd3,
    RSN_LENGTH     = 3'd4,
    RSN_RAW        = 3'd5,
    RSN_WAW        = 3'd6,
    RSN_ALONE      = 3'd7
  } reason_e;
endpackage

// File: rtl/pair_slot_rules.sv
module pair_slot_rules #(
  parameter int LEN_W = 4
) (
  input  logic             o_simple,
  input  logic             o_branch,
  input  logic             o_disp,
  input  logic             o_imm,
  input  logic [LEN_W-1:0] o_len,
  input  logic             o_seen,
  input  logic             y_simple,
  input  logic             y_shift,
  input  logic             y_carry,
  input  logic             y_prefix,
  input  logic             y_jcc,
  input  logic             y_disp,
  input  logic             y_imm,
  output logic             not_simple,
  output logic             slot_bad,
  output logic             disp_imm_bad,
  output logic             len_bad
);
  logic u_only_in_v;

  always_comb begin
    not_simple   = !(o_simple && y_simple);
    // R2: U-only classes in the younger slot; escaped Jcc is the exception
    u_only_in_v  = y_shift || y_carry || (y_prefix && !y_jcc);
    // R3: V-only classes in the older slot
    slot_bad     = u_only_in_v || o_branch;
    disp_imm_bad = (o_disp && o_imm) || (y_disp && y_imm);
    len_bad      = (o_len > LEN_W'(1)) && !o_seen;
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int MASK_W = NREG + 1
) (
  input  logic              o_flagalu,
  input  logic              o_push,
  input  logic              o_pop,
  input  logic              y_jcc,
  input  logic              y_push,
  input  logic              y_pop,
  input  logic [MASK_W-1:0] o_dst,
  input  logic [MASK_W-1:0] y_src,
  input  logic [MASK_W-1:0] y_dst,
  output logic              raw_hit,
  output logic              waw_hit
);
  localparam logic [MASK_W-1:0] FLAG_BIT = MASK_W'(1) << NREG;
  localparam logic [MASK_W-1:0] SP_BIT   = MASK_W'(1) << SP_IDX;

  logic              flag_ok, sp_ok;
  logic [MASK_W-1:0] raw_skip, waw_skip;

  always_comb begin
    flag_ok  = o_flagalu && y_jcc;                    // R6 exception
    sp_ok    = (o_push && y_push) || (o_pop && y_pop); // R7 exception
    raw_skip = (flag_ok ? FLAG_BIT : '0) | (sp_ok ? SP_BIT : '0);
    waw_skip = sp_ok ? SP_BIT : '0;
    raw_hit  = |(o_dst & y_src & ~raw_skip);
    waw_hit  = |(o_dst & y_dst & ~waw_skip);
  end
endmodule

// File: rtl/pair_reason_pick.sv
module pair_reason_pick
  import pair_pkg::*;
(
  input  logic             two,
  input  logic [NRULE-1:0] fail,
  output reason_e          reason
);
  always_comb begin
    reason = RSN_PAIR;
    if (!two) begin
      reason = RSN_ALONE;
    end else begin
      // R9: scan from highest to lowest so the lowest failing rule wins
      for (int i = NRULE - 1; i >= 0; i--) begin
        if (fail[i]) reason = reason_e'(3'(i + 1));
      end
    end
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int LEN_W  = 4,
  parameter int SP_IDX = 4,
  localparam int MASK_W = NREG + 1,
  localparam int DESC_W = NFLAG + 3 + LEN_W + 2 * MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic              win_two,
  input  logic [DESC_W-1:0] win_old,
  input  logic [DESC_W-1:0] win_yng,
  output logic              win_ready,
  output logic              win_pop2,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_dual,
  output logic [2:0]        iss_reason,
  output logic [DESC_W-1:0] iss_u_desc,
  output logic [DESC_W-1:0] iss_v_desc
);
  localparam int OFS_DISP = NFLAG;
  localparam int OFS_IMM  = NFLAG + 1;
  localparam int OFS_SEEN = NFLAG + 2;
  localparam int OFS_LEN  = NFLAG + 3;
  localparam int OFS_SRC  = OFS_LEN + LEN_W;
  localparam int OFS_DST  = OFS_SRC + MASK_W;
  localparam logic [MASK_W-1:0] PLAIN_GPR =
    {1'b0, {NREG{1'b1}}} & ~(MASK_W'(1) << SP_IDX);

  logic [NFLAG-1:0]  cls [2];
  logic              has_disp [2];
  logic              has_imm  [2];
  logic [MASK_W-1:0] dst [2];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_unpack
      logic [DESC_W-1:0] d;
      assign d           = (g == 0) ? win_old : win_yng;
      assign cls[g]      = d[NFLAG-1:0];
      assign has_disp[g] = d[OFS_DISP];
      assign has_imm[g]  = d[OFS_IMM];
      assign dst[g]      = d[OFS_DST +: MASK_W];
    end
  endgenerate

  logic [NRULE-1:0] fail;
  reason_e          reason_d;
  logic             accept, pair_ok;

  pair_slot_rules #(.LEN_W(LEN_W)) u_slot (
    .o_simple    (cls[0][F_SIMPLE]),
    .o_branch    (cls[0][F_BRANCH]),
    .o_disp      (has_disp[0]),
    .o_imm       (has_imm[0]),
    .o_len       (win_old[OFS_LEN +: LEN_W]),
    .o_seen      (win_old[OFS_SEEN]),
    .y_simple    (cls[1][F_SIMPLE]),
    .y_shift     (cls[1][F_SHIFT]),
    .y_carry     (cls[1][F_CARRY]),
    .y_prefix    (cls[1][F_PREFIX]),
    .y_jcc       (cls[1][F_JCC]),
    .y_disp      (has_disp[1]),
    .y_imm       (has_imm[1]),
    .not_simple  (fail[0]),
    .slot_bad    (fail[1]),
    .disp_imm_bad(fail[2]),
    .len_bad     (fail[3])
  );

  pair_hazard #(.NREG(NREG), .SP_IDX(SP_IDX)) u_haz (
    .o_flagalu(cls[0][F_FLAGALU]),
    .o_push   (cls[0][F_PUSH]),
    .o_pop    (cls[0][F_POP]),
    .y_jcc    (cls[1][F_JCC]),
    .y_push   (cls[1][F_PUSH]),
    .y_pop    (cls[1][F_POP]),
    .o_dst    (dst[0]),
    .y_src    (win_yng[OFS_SRC +: MASK_W]),
    .y_dst    (dst[1]),
    .raw_hit  (fail[4]),
    .waw_hit  (fail[5])
  );

  pair_reason_pick u_pick (
    .two   (win_two),
    .fail  (fail),
    .reason(reason_d)
  );

  assign win_ready = !iss_valid || iss_ready;
  assign accept    = win_valid && win_ready;
  assign pair_ok   = win_two && (reason_d == RSN_PAIR);
  assign win_pop2  = accept && pair_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid  <= 1'b0;
      iss_dual   <= 1'b0;
      iss_reason <= 3'd0;
      iss_u_desc <= '0;
      iss_v_desc <= '0;
    end else if (accept) begin
      iss_valid  <= 1'b1;
      iss_dual   <= pair_ok;
      iss_reason <= reason_d;
      iss_u_desc <= win_old;
      iss_v_desc <= pair_ok ? win_yng : '0;
    end else if (iss_ready) begin
      iss_valid  <= 1'b0;
    end
  end

  // R10: a two-entry pop only with a taken, two-entry window
  assert_pop2_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_pop2 |-> (win_valid && win_ready && win_two));

  // R8: lone descriptor issues alone with its own code
  assert_lone_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_two) |=> (iss_valid && !iss_dual && iss_reason == RSN_ALONE));

  // R11: stalled output holds
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_u_desc) &&
                                   $stable(iss_reason) && $stable(iss_dual)));

  // R3: a branch never takes the U slot of a pair
  assert_branch_not_u_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_two && win_old[F_BRANCH]) |=> !iss_dual);

  // R4: displacement plus immediate refuses, with no later rule reported
  assert_disp_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_two && ((win_old[OFS_DISP] && win_old[OFS_IMM]) ||
                           (win_yng[OFS_DISP] && win_yng[OFS_IMM])))
    |=> (!iss_dual && iss_reason <= RSN_DISP_IMM));

  // R6: an ordinary register read-after-write is never exempt
  assert_gpr_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_two &&
     |(win_old[OFS_DST +: MASK_W] & win_yng[OFS_SRC +: MASK_W] & PLAIN_GPR))
    |=> !iss_dual);
endmodule

// File: tb/tb_pair_issue_unit.sv
module tb_pair_issue_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          win_valid = 1'b0, win_two = 1'b0, iss_ready = 1'b1;
  logic [DW-1:0] win_old = '0, win_yng = '0;
  logic          win_ready, win_pop2, iss_valid, iss_dual;
  logic [2:0]    iss_reason;
  logic [DW-1:0] iss_u_desc, iss_v_desc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue_unit dut (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_two(win_two),
    .win_old(win_old), .win_yng(win_yng), .win_ready(win_ready),
    .win_pop2(win_pop2), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dual(iss_dual), .iss_reason(iss_reason),
    .iss_u_desc(iss_u_desc), .iss_v_desc(iss_v_desc)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // class bits per R1
  function automatic logic [8:0] kind_cls(input int k);
    case (k)
      0:  return 9'h001;                 // move
      1:  return 9'h081;                 // flag-writing ALU
      2:  return 9'h003;                 // shift
      3:  return 9'h085;                 // add-with-carry
      4:  return 9'h009;                 // jump
      5:  return 9'h109;                 // conditional jump
      6:  return 9'h119;                 // escaped conditional jump
      7:  return 9'h011;                 // prefixed move
      8:  return 9'h021;                 // push
      9:  return 9'h041;                 // pop
      10: return 9'h000;                 // complex
      default: return 9'h001;            // nop
    endcase
  endfunction

  function automatic logic [DW-1:0] mk(input int k, input bit old, input bit di,
                                        input bit lng, input bit seen, input int mode);
    logic [8:0] c, src, dst;
    c = kind_cls(k);
    if (old) begin
      src = 9'h001; dst = 9'h002;
    end else begin
      src = (mode == 1) ? 9'h002 : 9'h008;
      dst = (mode == 2) ? 9'h002 : 9'h040;
    end
    if (c[5] || c[6]) begin src |= 9'h010; dst |= 9'h010; end
    if (c[7]) dst |= 9'h100;
    if (c[2] || c[8]) src |= 9'h100;
    return {dst, src, (lng ? 4'd3 : 4'd1), seen, di, di, c};
  endfunction

  function automatic int ref_reason(input logic [DW-1:0] o, input logic [DW-1:0] y);
    logic [8:0] oc, yc, od, ys, yd, rs, ws;
    bit fx, sx;
    oc = o[8:0]; yc = y[8:0];
    od = o[33:25]; ys = y[24:16]; yd = y[33:25];
    if (!(oc[0] && yc[0])) return 1;                            // R1
    if (yc[1] || yc[2] || (yc[4] && !yc[8]) || oc[3]) return 2;  // R2 R3
    if ((o[9] && o[10]) || (y[9] && y[10])) return 3;           // R4
    if (o[15:12] > 4'd1 && !o[11]) return 4;                    // R5
    fx = oc[7] && yc[8];
    sx = (oc[5] && yc[5]) || (oc[6] && yc[6]);
    rs = (fx ? 9'h100 : 9'h0) | (sx ? 9'h010 : 9'h0);
    ws = sx ? 9'h010 : 9'h0;
    if (|(od & ys & ~rs)) return 5;                             // R6
    if (|(od & yd & ~ws)) return 6;                             // R7
    return 0;                                                   // R9
  endfunction

  function automatic string tag_of(input int r);
    case (r)
      0: return "R9";
      1: return "R1";
      2: return "R2/R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic run_pair(input logic [DW-1:0] o, input logic [DW-1:0] y);
    int e;
    e = ref_reason(o, y);
    win_valid = 1'b1; win_two = 1'b1; win_old = o; win_yng = y;
    #1;
    check(win_ready && (win_pop2 == (e == 0)), "R10", win_pop2, (e == 0));
    @(negedge clk);
    win_valid = 1'b0;
    check(iss_valid && iss_reason == 3'(e) && iss_dual == (e == 0) &&
          iss_u_desc == o && iss_v_desc == ((e == 0) ? y : '0),
          tag_of(e), iss_reason, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a, b;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!iss_valid && win_ready, "R12", iss_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!iss_valid, "R12", iss_valid, 0);

    // kind cross with register overlap patterns: R1 R2 R3 R6 R7 R9
    for (int m = 0; m < 3; m++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_pair(mk(i, 1, 0, 0, 0, m), mk(j, 0, 0, 0, 0, m));

    // operand form, length and seen-before sweep: R4 R5 R9
    for (int v = 0; v < 16; v++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_pair(mk(i, 1, v[0], v[2], v[3], 0), mk(j, 0, v[1], 0, 0, 0));

    // R8: lone descriptor, even a non-simple one with a hazardous partner present
    a = mk(10, 1, 1, 1, 0, 0);
    win_valid = 1'b1; win_two = 1'b0; win_old = a; win_yng = mk(0, 0, 0, 0, 0, 1);
    #1;
    check(win_ready && !win_pop2, "R8", win_pop2, 0);
    @(negedge clk);
    win_valid = 1'b0;
    check(iss_valid && !iss_dual && iss_reason == 3'd7 && iss_u_desc == a &&
          iss_v_desc == '0, "R8", iss_reason, 7);
    @(negedge clk);
    check(!iss_valid, "R10", iss_valid, 0);

    // R11: stall with a pair registered, next request waits
    a = mk(0, 1, 0, 0, 0, 0);
    b = mk(8, 1, 0, 0, 0, 0);
    iss_ready = 1'b0;
    win_valid = 1'b1; win_two = 1'b1; win_old = a; win_yng = mk(11, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(iss_valid && iss_dual && iss_u_desc == a, "R10", iss_u_desc, a);
    win_old = b; win_yng = mk(8, 0, 0, 0, 0, 0);
    for (int t = 0; t < 3; t++) begin
      #1;
      check(!win_ready && !win_pop2, "R10", win_ready, 0);
      @(negedge clk);
      check(iss_valid && iss_dual && iss_u_desc == a && iss_reason == 3'd0,
            "R11", iss_u_desc, a);
    end
    iss_ready = 1'b1;
    #1;
    check(win_ready && win_pop2, "R10", win_pop2, 1);   // push pair is exempt (R7)
    @(negedge clk);
    win_valid = 1'b0;
    check(iss_valid && iss_dual && iss_u_desc == b, "R11", iss_u_desc, b);
    @(negedge clk);
    check(!iss_valid, "R10", iss_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule